// File: doc/BRIEF.md
# Multi-Frame Transmit FIFO with Frame Counters

This block queues several variable-length frames written by a host and hands them one byte at a time to a serial framer. Bytes are located with a write byte pointer (`wr_ptr`) and a read byte pointer (`rd_ptr`). Frames are tracked with a write frame counter (`wr_frame`) and a read frame counter (`rd_frame`). A 32-entry end-address table holds the last address of every closed frame. A frame starts one address after the end of the frame before it, so no start table is needed.

The host writes bytes and closes a frame with an end-of-frame strobe. It may also pulse a select input, which starts transmission just as closing a frame does. The framer asks for bytes with a request and gets each byte one cycle later. It reports a finished frame with a done strobe. On a collision on the line it asks for a rewind, which replays the current frame from its first byte. The byte address space runs from `BASE` to `TOP` and wraps back to `BASE`, which is not zero. The defaults are 1C00h to 1FFFh, so the storage is 1024 bytes.

Top module: `txf_frame_fifo`

## Requirements
- R1: After reset, `wr_ptr` and `rd_ptr` equal `TOP`, `wr_frame` and `rd_frame` are 0, `empty` and `no_frame` are 1, and `rd_valid`, `tx_start` and `wr_drop` are 0.
- R2: Each accepted byte write advances `wr_ptr` by one address in the cycle after the write and stores the byte at the new `wr_ptr`.
- R3: An address step from `TOP` (default 1FFFh) goes to `BASE` (default 1C00h), for both pointers.
- R4: An accepted `wr_eof` records the frame's end address and increments `wr_frame` modulo 32 in the next cycle, after which `no_frame` is 0.
  - The end address is `wr_ptr` including any byte written in the same cycle.
- R5: An `rd_req` while `empty` is 0 advances `rd_ptr` by one. In the next cycle `rd_valid` is 1 and `rd_data` holds the byte at the new `rd_ptr`, so bytes leave in write order.
- R6: `empty` is 1 when `wr_frame` equals `rd_frame` or when `rd_ptr` equals the current frame's end address.
  - An `rd_req` while `empty` is 1 leaves `rd_ptr` unchanged and gives `rd_valid` 0.
- R7: An `rd_done` while a frame is pending increments `rd_frame` modulo 32 and moves `rd_ptr` to that frame's end address, so the next frame starts one address later.
  - An `rd_done` with no frame pending changes nothing.
- R8: An `rd_rewind` while a frame is pending reloads `rd_ptr` with the previous frame's end address, so the next byte read is the frame's first byte.
  - Priority is `rd_rewind` over `rd_done` over `rd_req`.
- R9: `tx_start` is 1 for one cycle after each cycle with `host_sel` high, which includes reselecting when already selected. It is also 1 for one cycle after each accepted `wr_eof`.
- R10: While the table is full (`wr_frame`+1 equals `rd_frame` modulo 32), `wr_en` and `wr_eof` are ignored: `wr_ptr` and `wr_frame` stay unchanged and `wr_drop` is 1 in the next cycle.
- R11: Both frame counters wrap from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host selects this FIFO; starts transmission |
| wr_en | input | 1 | Host byte write |
| wr_data | input | DATA_W | Host byte |
| wr_eof | input | 1 | Host end-of-frame strobe |
| rd_req | input | 1 | Framer byte request |
| rd_done | input | 1 | Framer finished the current frame |
| rd_rewind | input | 1 | Framer asks to replay the current frame |
| rd_data | output | DATA_W | Byte to the framer, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a requested byte |
| wr_ptr | output | ADDR_W | Address of the last byte written |
| rd_ptr | output | ADDR_W | Address of the last byte read |
| wr_frame | output | FCNT_W | Write frame counter |
| rd_frame | output | FCNT_W | Read frame counter |
| empty | output | 1 | No byte left to send in the current frame |
| no_frame | output | 1 | No closed frame pending |
| tx_start | output | 1 | Transmit-start event |
| wr_drop | output | 1 | Host write or end strobe was ignored because the table is full |

## Verification
The bench drives inputs at a falling edge and compares outputs at the next falling edge.

- **Pointers and counters:** `wr_ptr`, `rd_ptr`, `wr_frame` and `rd_frame` are compared one cycle after the stimulus.
- **Events and data:** `tx_start`, `wr_drop`, `rd_valid` and `rd_data` are compared in the same cycle, because each passes through exactly one register.
- **Status:** `empty` and `no_frame` are combinational decodes of those registers, so they are checked at the same sample point against the model's state after the edge.
- **Stimulus:** directed cases cover rewind, wrap, the full table and the counter wrap. They are followed by seeded random traffic, all predicted by a bench model that steps the requirements once per cycle.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_BYTE   = 2'd1,
    RD_NEXT   = 2'd2,
    RD_REWIND = 2'd3
  } rd_act_e;

  // step an address, folding TOP back onto a non-zero BASE
  function automatic logic [31:0] wrap_inc(input logic [31:0] a,
                                           input logic [31:0] base,
                                           input logic [31:0] top);
    return (a == top) ? base : a + 32'd1;
  endfunction
endpackage

// File: rtl/txf_ram.sv
module txf_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] BASE = 13'h1C00,
  parameter logic [ADDR_W-1:0] TOP  = 13'h1FFF
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = int'(TOP) - int'(BASE) + 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] woff, roff;

  assign woff = waddr - BASE;
  assign roff = raddr - BASE;

  always_ff @(posedge clk) begin
    if (we) mem[woff[IDX_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[roff[IDX_W-1:0]];
  end
endmodule

// File: rtl/txf_end_table.sv
module txf_end_table #(
  parameter int ADDR_W = 13,
  parameter int FCNT_W = 5,
  parameter logic [ADDR_W-1:0] TOP = 13'h1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [FCNT_W-1:0] widx,
  input  logic [ADDR_W-1:0] wend,
  input  logic [FCNT_W-1:0] ridx,
  output logic [ADDR_W-1:0] rend
);
  localparam int ENTRIES = 1 << FCNT_W;

  logic [ADDR_W-1:0] tab [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= TOP;
    end else if (we) begin
      tab[widx] <= wend;
    end
  end

  assign rend = tab[ridx];
endmodule

// File: rtl/txf_wr_ctrl.sv
module txf_wr_ctrl #(
  parameter int ADDR_W = 13,
  parameter int FCNT_W = 5,
  parameter logic [ADDR_W-1:0] BASE = 13'h1C00,
  parameter logic [ADDR_W-1:0] TOP  = 13'h1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              wr_en,
  input  logic              wr_eof,
  input  logic [FCNT_W-1:0] rd_frame,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [FCNT_W-1:0] wr_frame,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic              tab_we,
  output logic [FCNT_W-1:0] tab_idx,
  output logic [ADDR_W-1:0] tab_end,
  output logic              tx_start,
  output logic              wr_drop
);
  logic              full;
  logic              acc_byte, acc_eof;
  logic [ADDR_W-1:0] ptr_step, ptr_after;

  assign full      = (wr_frame + 1'b1) == rd_frame;
  assign acc_byte  = wr_en & ~full;
  assign acc_eof   = wr_eof & ~full;
  assign ptr_step  = ADDR_W'(txf_pkg::wrap_inc(32'(wr_ptr), 32'(BASE), 32'(TOP)));
  assign ptr_after = acc_byte ? ptr_step : wr_ptr;

  assign ram_we    = acc_byte;
  assign ram_waddr = ptr_step;
  assign tab_we    = acc_eof;
  assign tab_idx   = wr_frame;
  assign tab_end   = ptr_after;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= TOP;
      wr_frame <= '0;
      tx_start <= 1'b0;
      wr_drop  <= 1'b0;
    end else begin
      wr_ptr   <= ptr_after;
      if (acc_eof) wr_frame <= wr_frame + 1'b1;
      tx_start <= host_sel | acc_eof;
      wr_drop  <= (wr_en | wr_eof) & full;
    end
  end
endmodule

// File: rtl/txf_rd_ctrl.sv
module txf_rd_ctrl #(
  parameter int ADDR_W = 13,
  parameter int FCNT_W = 5,
  parameter logic [ADDR_W-1:0] BASE = 13'h1C00,
  parameter logic [ADDR_W-1:0] TOP  = 13'h1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              rd_done,
  input  logic              rd_rewind,
  input  logic [FCNT_W-1:0] wr_frame,
  input  logic [ADDR_W-1:0] cur_end,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [FCNT_W-1:0] rd_frame,
  output logic              empty,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              rd_valid
);
  txf_pkg::rd_act_e act;
  logic              pending;
  logic [ADDR_W-1:0] prev_end;

  assign pending   = wr_frame != rd_frame;
  assign empty     = ~pending | (rd_ptr == cur_end);
  assign ram_raddr = ADDR_W'(txf_pkg::wrap_inc(32'(rd_ptr), 32'(BASE), 32'(TOP)));
  assign ram_re    = (act == txf_pkg::RD_BYTE);

  always_comb begin
    if (rd_rewind && pending)    act = txf_pkg::RD_REWIND;
    else if (rd_done && pending) act = txf_pkg::RD_NEXT;
    else if (rd_req && !empty)   act = txf_pkg::RD_BYTE;
    else                         act = txf_pkg::RD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr   <= TOP;
      prev_end <= TOP;
      rd_frame <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= (act == txf_pkg::RD_BYTE);
      case (act)
        txf_pkg::RD_REWIND: rd_ptr <= prev_end;
        txf_pkg::RD_NEXT: begin
          rd_ptr   <= cur_end;
          prev_end <= cur_end;
          rd_frame <= rd_frame + 1'b1;
        end
        txf_pkg::RD_BYTE: rd_ptr <= ram_raddr;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txf_frame_fifo.sv
module txf_frame_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 13,
  parameter int FCNT_W = 5,
  parameter logic [ADDR_W-1:0] BASE = 13'h1C00,
  parameter logic [ADDR_W-1:0] TOP  = 13'h1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eof,
  input  logic              rd_req,
  input  logic              rd_done,
  input  logic              rd_rewind,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [FCNT_W-1:0] wr_frame,
  output logic [FCNT_W-1:0] rd_frame,
  output logic              empty,
  output logic              no_frame,
  output logic              tx_start,
  output logic              wr_drop
);
  logic              ram_we, ram_re, tab_we;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr, tab_end, cur_end;
  logic [FCNT_W-1:0] tab_idx;

  txf_wr_ctrl #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W), .BASE(BASE), .TOP(TOP)) u_wr (
    .clk(clk), .rst(rst), .host_sel(host_sel), .wr_en(wr_en), .wr_eof(wr_eof),
    .rd_frame(rd_frame), .wr_ptr(wr_ptr), .wr_frame(wr_frame),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .tab_we(tab_we), .tab_idx(tab_idx),
    .tab_end(tab_end), .tx_start(tx_start), .wr_drop(wr_drop)
  );

  txf_end_table #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W), .TOP(TOP)) u_tab (
    .clk(clk), .rst(rst), .we(tab_we), .widx(tab_idx), .wend(tab_end),
    .ridx(rd_frame), .rend(cur_end)
  );

  txf_rd_ctrl #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W), .BASE(BASE), .TOP(TOP)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_done(rd_done), .rd_rewind(rd_rewind),
    .wr_frame(wr_frame), .cur_end(cur_end), .rd_ptr(rd_ptr), .rd_frame(rd_frame),
    .empty(empty), .ram_re(ram_re), .ram_raddr(ram_raddr), .rd_valid(rd_valid)
  );

  txf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE), .TOP(TOP)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
    .re(ram_re), .raddr(ram_raddr), .rdata(rd_data)
  );

  assign no_frame = (wr_frame == rd_frame);
endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
  parameter int ADDR_W = 13,
  parameter int FCNT_W = 5,
  parameter logic [ADDR_W-1:0] BASE = 13'h1C00,
  parameter logic [ADDR_W-1:0] TOP  = 13'h1FFF
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [FCNT_W-1:0] wr_frame,
  input logic [FCNT_W-1:0] rd_frame,
  input logic              empty,
  input logic              tx_start,
  input logic              wr_drop
);
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr >= BASE) && (wr_ptr <= TOP) && (rd_ptr >= BASE) && (rd_ptr <= TOP));

  p_wr_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_ptr) == TOP && wr_ptr != $past(wr_ptr)) |-> wr_ptr == BASE);

  p_frame_step_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_frame != $past(wr_frame)) |-> wr_frame == FCNT_W'($past(wr_frame) + 1'b1));

  p_read_gate_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req && !empty));

  p_done_pending_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_frame != $past(rd_frame)) |-> $past(wr_frame != rd_frame));

  p_tx_cause_r9: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> ($past(host_sel) || wr_frame != $past(wr_frame)));

  p_drop_hold_r10: assert property (@(posedge clk) disable iff (rst)
    wr_drop |-> ($stable(wr_ptr) && $stable(wr_frame)));
endmodule

bind txf_frame_fifo txf_checker #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W), .BASE(BASE), .TOP(TOP)) u_chk (
  .clk(clk), .rst(rst), .host_sel(host_sel), .rd_req(rd_req), .rd_valid(rd_valid),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_frame(wr_frame), .rd_frame(rd_frame),
  .empty(empty), .tx_start(tx_start), .wr_drop(wr_drop)
);

// File: tb/sim_txf_frame_fifo.sv
`timescale 1ns/1ps
module sim_txf_frame_fifo;
  localparam logic [12:0] BASE = 13'h1C00;
  localparam logic [12:0] TOP  = 13'h1FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_sel = 0, wr_en = 0, wr_eof = 0, rd_req = 0, rd_done = 0, rd_rewind = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_data;
  logic        rd_valid, empty, no_frame, tx_start, wr_drop;
  logic [12:0] wr_ptr, rd_ptr;
  logic [4:0]  wr_frame, rd_frame;

  always #2 clk = ~clk;

  txf_frame_fifo u0 (
    .clk(clk), .rst(rst), .host_sel(host_sel), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eof(wr_eof), .rd_req(rd_req), .rd_done(rd_done), .rd_rewind(rd_rewind),
    .rd_data(rd_data), .rd_valid(rd_valid), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .wr_frame(wr_frame), .rd_frame(rd_frame), .empty(empty), .no_frame(no_frame),
    .tx_start(tx_start), .wr_drop(wr_drop)
  );

  int checks = 0;
  int errors = 0;

  // bench model of the requirements
  logic [12:0] m_wp = TOP, m_rp = TOP, m_prev = TOP;
  logic [4:0]  m_wf = 0, m_rf = 0;
  logic [12:0] m_tab [32];
  logic [7:0]  m_mem [int];

  function automatic logic [12:0] step(input logic [12:0] a);
    return (a == TOP) ? BASE : a + 13'd1;
  endfunction

  function automatic bit m_empty();
    return (m_wf == m_rf) || (m_rp == m_tab[m_rf]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input bit w, input logic [7:0] d, input bit e,
                     input bit rq, input bit dn, input bit rw);
    bit full, aw, ae, pend, emp, e_valid;
    logic [7:0] e_data;
    logic [12:0] pre_wp;
    logic [4:0] pre_wf;
    host_sel = s; wr_en = w; wr_data = d; wr_eof = e;
    rd_req = rq; rd_done = dn; rd_rewind = rw;
    pre_wp = m_wp; pre_wf = m_wf;
    full = (5'(m_wf + 5'd1) == m_rf);
    aw = w && !full; ae = e && !full;
    pend = m_wf != m_rf;
    emp = m_empty();
    e_valid = 0; e_data = 0;
    if (rw && pend) m_rp = m_prev;
    else if (dn && pend) begin
      m_rp = m_tab[m_rf]; m_prev = m_tab[m_rf]; m_rf = m_rf + 5'd1;
    end else if (rq && !emp) begin
      m_rp = step(m_rp); e_valid = 1; e_data = m_mem[int'(m_rp)];
    end
    if (aw) begin m_wp = step(m_wp); m_mem[int'(m_wp)] = d; end
    if (ae) begin m_tab[pre_wf] = m_wp; m_wf = m_wf + 5'd1; end
    @(posedge clk);
    @(negedge clk);
    host_sel = 0; wr_en = 0; wr_eof = 0; rd_req = 0; rd_done = 0; rd_rewind = 0;
    chk("R2 wr_ptr", 32'(wr_ptr), 32'(m_wp));
    chk("R5 rd_ptr", 32'(rd_ptr), 32'(m_rp));
    chk("R4 wr_frame", 32'(wr_frame), 32'(m_wf));
    chk("R7 rd_frame", 32'(rd_frame), 32'(m_rf));
    chk("R6 empty", 32'(empty), 32'(m_empty()));
    chk("R4 no_frame", 32'(no_frame), 32'(m_wf == m_rf));
    chk("R5 rd_valid", 32'(rd_valid), 32'(e_valid));
    if (e_valid) chk("R5 rd_data", 32'(rd_data), 32'(e_data));
    chk("R9 tx_start", 32'(tx_start), 32'(s || ae));
    chk("R10 wr_drop", 32'(wr_drop), 32'((w || e) && full));
    if (aw && pre_wp == TOP) chk("R3 wrap", 32'(wr_ptr), 32'(BASE));
    if (ae && pre_wf == 5'd31) chk("R11 frame wrap", 32'(wr_frame), 32'd0);
  endtask

  task automatic drain_frame();
    while (!m_empty()) cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_tab[i] = TOP;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 wr_ptr", 32'(wr_ptr), 32'(TOP));
    chk("R1 rd_ptr", 32'(rd_ptr), 32'(TOP));
    chk("R1 frames", 32'({wr_frame, rd_frame}), 32'd0);
    chk("R1 flags", 32'({empty, no_frame, rd_valid, tx_start, wr_drop}), 32'b11000);

    // ignored reads and done with nothing pending
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R6 ignored read", 32'(rd_ptr), 32'(TOP));
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R7 ignored done", 32'(rd_frame), 32'd0);

    // select and reselect
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R9 reselect", 32'(tx_start), 32'd1);

    // frame of 5 bytes, last byte with eof
    for (int i = 0; i < 4; i++) cyc(0, 1, 8'h10 + 8'(i), 0, 0, 0, 0);
    cyc(0, 1, 8'h14, 1, 0, 0, 0);
    chk("R4 end", 32'(no_frame), 32'd0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 1);
    chk("R8 rewind", 32'(rd_ptr), 32'(TOP));
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R8 first byte", 32'(rd_data), 32'h10);
    drain_frame();
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R6 frame over", 32'(rd_valid), 32'd0);

    // long frame through the wrap
    for (int i = 0; i < 1030; i++) cyc(0, 1, 8'(i * 7), (i == 1029), 0, 0, 0);
    drain_frame();
    chk("R3 rd wrap", 32'(rd_ptr), 32'(m_wp));

    // fill the table, then try to write
    for (int i = 0; i < 31; i++) cyc(0, 1, 8'(i), 1, 0, 0, 0);
    cyc(0, 1, 8'hAA, 0, 0, 0, 0);
    chk("R10 drop", 32'(wr_drop), 32'd1);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R10 frame hold", 32'(wr_frame), 32'(m_wf));
    for (int i = 0; i < 31; i++) drain_frame();
    chk("R11 rd_frame", 32'(rd_frame), 32'(m_rf));

    // seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      bit s, w, e, rq, dn, rw;
      int r;
      r  = $urandom_range(99);
      s  = ($urandom_range(99) < 3);
      w  = (r < 45);
      e  = ($urandom_range(99) < 8);
      rq = ($urandom_range(99) < 45);
      dn = m_empty() && ($urandom_range(99) < 50);
      rw = ($urandom_range(99) < 2);
      cyc(s, w, 8'($urandom), e, rq, dn, rw);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule